// File: doc/BRIEF.md
# Two-Way Buffered Bus Steering Unit

This unit sits between two 9-bit bidirectional buses, called A and B, and two queues. The forward queue carries words from A towards B. The return queue carries words from B towards A. Each direction has its own source choice. It can pass the live value seen on the opposite bus straight across, or it can present the word at the read side of its queue. The queues themselves are outside this unit. Only their read data enters it.

A shared pair of controls decides which bus, if any, the unit drives. When the disable control is high, neither bus is driven. When it is low, the direction control picks exactly one bus. Every output is taken from a flop on the system clock. As a result, a change of source never makes a combinational glitch at a pad driver: the new value appears cleanly at the next edge.

The live value of a bus that the unit is driving is its own echo. It must not be captured as fresh data. While a bus is driven, the crossing path that reads it holds its last captured word.

Top module: `bidir_xcvr_steer`

## Requirements
- R1: While `rst` is high at a clock edge, all four outputs (`a_out`, `a_oe`, `b_out`, `b_oe`) become 0 after that edge.
- R2: With `sel_ab_stored`=0 and `a_oe`=0 at an edge, `b_out` equals the `a_in` value sampled at that edge, one cycle later.
- R3: With `sel_ab_stored`=1 at an edge, `b_out` equals the `fifo_a_rd` value sampled at that edge, one cycle later.
- R4: With `sel_ba_stored`=0 and `b_oe`=0 at an edge, `a_out` equals the sampled `b_in`, one cycle later.
- R5: With `sel_ba_stored`=1 at an edge, `a_out` equals the sampled `fifo_b_rd`, one cycle later.
- R6: If `bus_off`=1 at an edge, both `a_oe` and `b_oe` are 0 after it, whatever `dir_to_b` is.
- R7: If `bus_off`=0 and `dir_to_b`=1 at an edge, then `b_oe`=1 and `a_oe`=0 after it.
- R8: If `bus_off`=0 and `dir_to_b`=0 at an edge, then `a_oe`=1 and `b_oe`=0 after it.
- R9: At most one of `a_oe` and `b_oe` is 1 in any cycle.
- R10: Outputs change only at rising clock edges. A change of select or data between edges leaves `a_out`/`b_out` unchanged until the next edge.
- R11: If the live path is selected while the source bus is being driven (`a_oe`=1 for A to B, `b_oe`=1 for B to A) at an edge, the crossing output keeps its previous value. The driven bus's input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_ab_stored | input | 1 | A to B source: 0 = live A bus, 1 = forward queue word |
| sel_ba_stored | input | 1 | B to A source: 0 = live B bus, 1 = return queue word |
| bus_off | input | 1 | 1 = drive neither bus |
| dir_to_b | input | 1 | With bus_off=0: 1 = drive B, 0 = drive A |
| a_in | input | W | Value currently seen on bus A |
| b_in | input | W | Value currently seen on bus B |
| fifo_a_rd | input | W | Read word of the forward (A to B) queue |
| fifo_b_rd | input | W | Read word of the return (B to A) queue |
| a_out | output | W | Registered value for the A bus driver |
| a_oe | output | 1 | Drive enable of bus A, active high |
| b_out | output | W | Registered value for the B bus driver |
| b_oe | output | 1 | Drive enable of bus B, active high |

## Verification
The bound checker evaluates several properties on every cycle:
- the drive table and the rule that at most one bus is driven;
- the one-cycle relation between each selected source and its crossing output;
- the hold of a crossing output while its source bus is driven.

Some behaviour can only be shown by the directed scenarios. These include the absence of change between edges when selects and data move mid-cycle. They also include the full sequence of entering and leaving a drive state with live data selected, and the reset values seen at the ports.

// File: rtl/xcvr_steer_pkg.sv
package xcvr_steer_pkg;
  localparam int LANES = 2;
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drv_mode_e;
endpackage

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
  import xcvr_steer_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bus_off,
  input  logic dir_to_b,
  output logic a_oe,
  output logic b_oe
);
  drv_mode_e mode;

  always_comb begin
    if (bus_off)       mode = DRV_NONE;
    else if (dir_to_b) mode = DRV_B;
    else               mode = DRV_A;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_oe <= 1'b0;
      b_oe <= 1'b0;
    end else begin
      a_oe <= (mode == DRV_A);
      b_oe <= (mode == DRV_B);
    end
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_stored,
  input  logic         src_driven,
  input  logic [W-1:0] live_in,
  input  logic [W-1:0] stored_in,
  output logic [W-1:0] out_q
);
  // Registered source choice: the pad only ever sees a flop output.
  always_ff @(posedge clk) begin
    if (rst)              out_q <= '0;
    else if (sel_stored)  out_q <= stored_in;
    else if (!src_driven) out_q <= live_in;
  end
endmodule

// File: rtl/bidir_xcvr_steer.sv
module bidir_xcvr_steer
  import xcvr_steer_pkg::*;
#(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_ab_stored,
  input  logic         sel_ba_stored,
  input  logic         bus_off,
  input  logic         dir_to_b,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] fifo_a_rd,
  input  logic [W-1:0] fifo_b_rd,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  // Lane 0 carries A to B, lane 1 carries B to A.
  logic [LANES-1:0][W-1:0] live, stored, q;
  logic [LANES-1:0]        sel, srcdrv;

  assign live[0]   = a_in;
  assign stored[0] = fifo_a_rd;
  assign sel[0]    = sel_ab_stored;
  assign srcdrv[0] = a_oe;
  assign live[1]   = b_in;
  assign stored[1] = fifo_b_rd;
  assign sel[1]    = sel_ba_stored;
  assign srcdrv[1] = b_oe;

  xcvr_drive_ctl u_drv (
    .clk      (clk),
    .rst      (rst),
    .bus_off  (bus_off),
    .dir_to_b (dir_to_b),
    .a_oe     (a_oe),
    .b_oe     (b_oe)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    xcvr_lane #(.W(W)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .sel_stored (sel[g]),
      .src_driven (srcdrv[g]),
      .live_in    (live[g]),
      .stored_in  (stored[g]),
      .out_q      (q[g])
    );
  end

  assign b_out = q[0];
  assign a_out = q[1];
endmodule

// File: rtl/xcvr_steer_chk.sv
module xcvr_steer_chk #(
  parameter int W = 9
) (
  input logic         clk,
  input logic         rst,
  input logic         sel_ab_stored,
  input logic         sel_ba_stored,
  input logic         bus_off,
  input logic         dir_to_b,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] fifo_a_rd,
  input logic [W-1:0] fifo_b_rd,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_out,
  input logic         b_oe
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

  assert_live_ab_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sel_ab_stored) && !$past(a_oe)) |-> b_out == $past(a_in));

  assert_stored_ab_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel_ab_stored)) |-> b_out == $past(fifo_a_rd));

  assert_live_ba_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sel_ba_stored) && !$past(b_oe)) |-> a_out == $past(b_in));

  assert_stored_ba_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel_ba_stored)) |-> a_out == $past(fifo_b_rd));

  assert_off_R6: assert property (@(posedge clk) disable iff (rst)
    $past(bus_off) |-> (!a_oe && !b_oe));

  assert_drive_b_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_off) && $past(dir_to_b)) |-> (b_oe && !a_oe));

  assert_drive_a_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_off) && !$past(dir_to_b)) |-> (a_oe && !b_oe));

  assert_one_driver_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({a_oe, b_oe}));

  assert_hold_ab_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sel_ab_stored) && $past(a_oe)) |-> $stable(b_out));

  assert_hold_ba_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sel_ba_stored) && $past(b_oe)) |-> $stable(a_out));
endmodule

bind bidir_xcvr_steer xcvr_steer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .sel_ab_stored(sel_ab_stored), .sel_ba_stored(sel_ba_stored),
  .bus_off(bus_off), .dir_to_b(dir_to_b), .a_in(a_in), .b_in(b_in),
  .fifo_a_rd(fifo_a_rd), .fifo_b_rd(fifo_b_rd), .a_out(a_out), .a_oe(a_oe),
  .b_out(b_out), .b_oe(b_oe)
);

// File: tb/test_bidir_xcvr_steer.sv
`timescale 1ns/1ps
module test_bidir_xcvr_steer;
  localparam int W = 9;
  logic clk = 1'b0;
  logic rst, sel_ab, sel_ba, bus_off, dir_to_b;
  logic [W-1:0] a_in, b_in, fa, fb, a_out, b_out;
  logic a_oe, b_oe;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  bidir_xcvr_steer #(.W(W)) i_bidir_xcvr_steer (
    .clk(clk), .rst(rst), .sel_ab_stored(sel_ab), .sel_ba_stored(sel_ba),
    .bus_off(bus_off), .dir_to_b(dir_to_b), .a_in(a_in), .b_in(b_in),
    .fifo_a_rd(fa), .fifo_b_rd(fb), .a_out(a_out), .a_oe(a_oe),
    .b_out(b_out), .b_oe(b_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1; sel_ab = 0; sel_ba = 0; bus_off = 0; dir_to_b = 1;
    a_in = 9'h1FF; b_in = 9'h1FF; fa = 9'h1FF; fb = 9'h1FF;
    tick(); tick();
    check("R1 a_oe", a_oe, 0); check("R1 b_oe", b_oe, 0);
    check("R1 a_out", a_out, 0); check("R1 b_out", b_out, 0);
    rst = 0; bus_off = 1;
    tick();
  endtask

  task automatic t_sources();
    bus_off = 1;
    sel_ab = 0; a_in = 9'h055; fa = 9'h0AA;
    sel_ba = 0; b_in = 9'h123; fb = 9'h0F0;
    tick();
    check("R2 live A->B", b_out, 9'h055);
    check("R4 live B->A", a_out, 9'h123);
    sel_ab = 1; sel_ba = 1;
    tick();
    check("R3 stored A->B", b_out, 9'h0AA);
    check("R5 stored B->A", a_out, 9'h0F0);
    fa = 9'h100; fb = 9'h001;
    tick();
    check("R3 stored A->B new", b_out, 9'h100);
    check("R5 stored B->A new", a_out, 9'h001);
    sel_ab = 0; sel_ba = 0; a_in = 9'h1FE; b_in = 9'h000;
    tick();
    check("R2 live A->B back", b_out, 9'h1FE);
    check("R4 live B->A back", a_out, 9'h000);
  endtask

  task automatic t_drive_table();
    for (int d = 0; d < 2; d++) begin
      bus_off = 1; dir_to_b = d[0];
      tick();
      check("R6 off a_oe", a_oe, 0); check("R6 off b_oe", b_oe, 0);
    end
    bus_off = 0; dir_to_b = 1;
    tick();
    check("R7 b_oe", b_oe, 1); check("R7 a_oe", a_oe, 0);
    check("R9 one driver", a_oe + b_oe, 1);
    dir_to_b = 0;
    tick();
    check("R8 a_oe", a_oe, 1); check("R8 b_oe", b_oe, 0);
    bus_off = 1;
    tick();
    check("R6 release", a_oe + b_oe, 0);
  endtask

  task automatic t_no_glitch();
    bus_off = 1; sel_ab = 0; a_in = 9'h011; fa = 9'h1EE;
    tick();
    check("R10 start", b_out, 9'h011);
    #1 sel_ab = 1; a_in = 9'h033;
    #1 check("R10 between edges", b_out, 9'h011);
    fb = 9'h0C3; sel_ba = 1;
    #1 check("R10 between edges BA", a_out, b_in);
    tick();
    check("R10 after edge", b_out, 9'h1EE);
    check("R10 after edge BA", a_out, 9'h0C3);
  endtask

  task automatic t_loopback();
    sel_ab = 0; sel_ba = 0; bus_off = 1; a_in = 9'h055; b_in = 9'h066;
    tick();
    check("R11 setup", b_out, 9'h055);
    bus_off = 0; dir_to_b = 0;
    tick();
    check("R11 A driven", a_oe, 1);
    a_in = 9'h1AA;
    tick();
    check("R11 A echo ignored", b_out, 9'h055);
    tick();
    check("R11 A echo still ignored", b_out, 9'h055);
    bus_off = 1;
    tick();
    check("R11 release edge holds", b_out, 9'h055);
    tick();
    check("R11 capture after release", b_out, 9'h1AA);
    bus_off = 0; dir_to_b = 1;
    tick();
    b_in = 9'h099;
    tick();
    check("R11 B echo ignored", a_out, 9'h066);
    bus_off = 1;
    tick(); tick();
    check("R11 B capture after release", a_out, 9'h099);
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_sources();
    t_drive_table();
    t_no_glitch();
    t_loopback();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule